// File: doc/BRIEF.md
# SPI Memory Sequential Read Engine

This block is the read path of a serial memory slave on an SPI bus in mode 0. While the active-low chip select is held low, the block shifts in an 8-bit opcode and then a 16-bit address on the serial input. Both fields arrive MSB first and are sampled on rising serial-clock edges. If the opcode is the read command, the block starts to drive bytes from an internal byte array on the serial output, MSB first, changing the line after falling serial-clock edges. It keeps streaming successive bytes for as long as the master keeps clocking. The address wraps at the top of the array.

All serial pins are oversampled by the block's own system clock. Each pin passes through a synchronizer, and the serial-clock edges are detected as single-cycle pulses. The pad tri-state is shown by an output-enable signal, `so_oe`, next to the data bit `so`: the pad is in high impedance whenever `so_oe` is low. A separate one-cycle load port writes the byte array directly. It exists for test setup and array preload.

Top module: `spi_rd_engine`

## Requirements
- R1: During and after synchronous reset, `so_oe` is low and the engine waits for a new frame.
- R2: A frame starts when `cs_n` falls. Bits are taken from `si` on rising `sck` edges, MSB first: 8 opcode bits, then 16 address bits. The bit count stops at 24.
- R3: `so_oe` stays low while the 24 opcode and address bits are clocked in.
- R4: When the opcode is 0x03, the addressed byte appears on `so` MSB first. Bit 7 is valid after the falling edge that follows the 24th rising edge, and `so` only changes after falling `sck` edges.
- R5: Every further 8 clocks output the byte at the next higher address, for as long as clocking continues.
- R6: Only the low `MEM_AW` address bits select a byte and the higher address bits are ignored. After address 2^MEM_AW-1 the next byte comes from address 0. With the default this is 0x0FFF to 0x0000.
- R7: With any opcode other than 0x03, `so_oe` stays low until `cs_n` rises.
- R8: When `cs_n` rises at any point, `so_oe` goes low within `SYNC_STAGES`+2 system clocks and the bit count returns to zero. The next frame is decoded from its first bit.
- R9: When `ld_en` is high on a clock edge, `ld_data` is written to array address `ld_addr`, and a later read returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low (mode 0) |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data pad; low means high impedance |
| ld_en | input | 1 | Backdoor array write strobe |
| ld_addr | input | MEM_AW | Backdoor write address |
| ld_data | input | 8 | Backdoor write byte |

## Verification
The bench builds the engine with `MEM_AW` = 6, so the array holds 64 bytes and a burst crosses from 0x3F to 0x00 within a few bytes. This also makes most address bits lie above the array, so the test of ignored upper bits is meaningful. `SYNC_STAGES` stays at 2, and the serial clock runs with 8 system clocks per half period. This leaves the synchronizer and prefetch latency well inside each half period while keeping every scenario short.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    localparam int OPC_W      = 8;
    localparam int ADR_W      = 16;
    localparam int FRAME_BITS = OPC_W + ADR_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [OPC_W-1:0] RD_OPC = 8'h03;

    typedef enum logic [1:0] {
        PH_OPC  = 2'd0,
        PH_ADR  = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_t;

    typedef struct packed {
        phase_t           phase;
        logic [CNT_W-1:0] cnt;
    } frame_st_t;

    typedef struct packed {
        logic cs_act;
        logic rise;
        logic fall;
        logic si;
    } pin_ev_t;

    function automatic logic is_read(input logic [OPC_W-1:0] op);
        return op == RD_OPC;
    endfunction

    function automatic phase_t phase_after_opc(input logic [OPC_W-1:0] op);
        return is_read(op) ? PH_ADR : PH_SKIP;
    endfunction

endpackage

// File: rtl/spi_rd_pins.sv
module spi_rd_pins
    import spi_rd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    si,
    output pin_ev_t ev
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] RST_VAL = 3'b100;

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] synced;
    logic            sck_prev;

    assign raw = {cs_n, sck, si};

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {SYNC_STAGES{RST_VAL[p]}};
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], raw[p]};
            end
        end
        assign synced[p] = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= synced[1];
        end
    end

    always_comb begin
        ev.cs_act = ~synced[2];
        ev.rise   = synced[1] & ~sck_prev;
        ev.fall   = ~synced[1] & sck_prev;
        ev.si     = synced[0];
    end

endmodule

// File: rtl/spi_rd_frame.sv
module spi_rd_frame
    import spi_rd_pkg::*;
#(
    parameter int MEM_AW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           ev,
    input  logic              take,
    output frame_st_t         st,
    output logic [OPC_W-1:0]  opc,
    output logic [MEM_AW-1:0] ptr
);
    localparam logic [CNT_W-1:0] LAST_OPC = CNT_W'(OPC_W - 1);
    localparam logic [CNT_W-1:0] LAST_ADR = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS);

    logic [OPC_W-1:0] opc_nx;
    assign opc_nx = {opc[OPC_W-2:0], ev.si};

    always_ff @(posedge clk) begin
        if (rst || !ev.cs_act) begin
            st.phase <= PH_OPC;
            st.cnt   <= '0;
            if (rst) begin
                opc <= '0;
            end
        end else if (ev.rise) begin
            if (st.cnt != CNT_MAX) begin
                st.cnt <= st.cnt + 1'b1;
            end
            unique case (st.phase)
                PH_OPC: begin
                    opc <= opc_nx;
                    if (st.cnt == LAST_OPC) begin
                        st.phase <= phase_after_opc(opc_nx);
                    end
                end
                PH_ADR: begin
                    if (st.cnt == LAST_ADR) begin
                        st.phase <= PH_DATA;
                    end
                end
                PH_DATA: ;
                PH_SKIP: ;
            endcase
        end
    end

    // Address pointer: shifted in during the address phase, stepped per byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ev.cs_act && ev.rise && st.phase == PH_ADR) begin
            ptr <= {ptr[MEM_AW-2:0], ev.si};
        end else if (take) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem #(
    parameter int MEM_AW = 12
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
        rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/spi_rd_shift.sv
module spi_rd_shift
    import spi_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pin_ev_t    ev,
    input  logic       data_ph,
    input  logic [7:0] byte_in,
    output logic       take,
    output logic       so,
    output logic       so_oe
);
    logic [6:0] rest;
    logic [2:0] left;
    logic       step;

    assign step = ev.cs_act & ev.fall & data_ph;
    assign take = step & (left == 3'd0);

    always_ff @(posedge clk) begin
        if (rst || !ev.cs_act) begin
            so_oe <= 1'b0;
            so    <= 1'b0;
            rest  <= '0;
            left  <= '0;
        end else if (step) begin
            if (left == 3'd0) begin
                so    <= byte_in[7];
                rest  <= byte_in[6:0];
                left  <= 3'd7;
                so_oe <= 1'b1;
            end else begin
                so   <= rest[6];
                rest <= {rest[5:0], 1'b0};
                left <= left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_rd_engine.sv
module spi_rd_engine
    import spi_rd_pkg::*;
#(
    parameter int MEM_AW      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [7:0]        ld_data
);
    pin_ev_t           ev;
    frame_st_t         st;
    logic [OPC_W-1:0]  opc;
    logic [MEM_AW-1:0] ptr;
    logic [7:0]        mem_q;
    logic              take;
    logic              data_ph;

    assign data_ph = (st.phase == PH_DATA);

    spi_rd_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
        .clk (clk),
        .rst (rst),
        .cs_n(cs_n),
        .sck (sck),
        .si  (si),
        .ev  (ev)
    );

    spi_rd_frame #(.MEM_AW(MEM_AW)) u_frame (
        .clk (clk),
        .rst (rst),
        .ev  (ev),
        .take(take),
        .st  (st),
        .opc (opc),
        .ptr (ptr)
    );

    spi_rd_mem #(.MEM_AW(MEM_AW)) u_mem (
        .clk    (clk),
        .wr_en  (ld_en),
        .wr_addr(ld_addr),
        .wr_data(ld_data),
        .rd_addr(ptr),
        .rd_data(mem_q)
    );

    spi_rd_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .data_ph(data_ph),
        .byte_in(mem_q),
        .take   (take),
        .so     (so),
        .so_oe  (so_oe)
    );

endmodule

// File: rtl/spi_rd_engine_chk.sv
module spi_rd_engine_chk
    import spi_rd_pkg::*;
#(
    parameter int MEM_AW = 12
) (
    input logic              clk,
    input logic              rst,
    input pin_ev_t           ev,
    input frame_st_t         st,
    input logic [OPC_W-1:0]  opc,
    input logic [MEM_AW-1:0] ptr,
    input logic              take,
    input logic              so,
    input logic              so_oe
);
    assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !so_oe);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        st.cnt <= CNT_W'(FRAME_BITS));

    assert_oe_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(so_oe) |-> $past(ev.fall));

    assert_so_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (so_oe && $past(so_oe) && so != $past(so)) |-> $past(ev.fall));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        take |=> ptr == $past(ptr) + 1'b1);

    assert_read_only_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(so_oe) |-> opc == RD_OPC);

    assert_cs_release_R8: assert property (@(posedge clk) disable iff (rst)
        !ev.cs_act |=> (!so_oe && st.cnt == '0));

endmodule

bind spi_rd_engine spi_rd_engine_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .ev   (ev),
    .st   (st),
    .opc  (opc),
    .ptr  (ptr),
    .take (take),
    .so   (so),
    .so_oe(so_oe)
);

// File: tb/tb_spi_rd_engine.sv
module tb_spi_rd_engine;
    localparam int MEM_AW = 6;
    localparam int HALF   = 8;
    localparam int DEPTH  = 1 << MEM_AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so, so_oe;
    logic ld_en = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [7:0] ld_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    spi_rd_engine #(.MEM_AW(MEM_AW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = MEM_AW'(a); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        model[a] = d;
    endtask

    // One SPI clock: drive si, sample so/so_oe just before the rising edge.
    task automatic xfer(input logic b, output logic so_v, output logic oe_v);
        si = b;
        wait_clk(HALF);
        so_v = so; oe_v = so_oe;
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
    endtask

    task automatic select();
        @(negedge clk);
        sck = 1'b0; cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic deselect();
        @(negedge clk);
        sck = 1'b0; cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    // Sends opcode+address; returns 1 if so_oe was seen high during them.
    task automatic send_hdr(input logic [7:0] op, input logic [15:0] adr, output logic oe_any);
        logic [23:0] v;
        logic s, o;
        v = {op, adr};
        oe_any = 1'b0;
        for (int i = 23; i >= 0; i--) begin
            xfer(v[i], s, o);
            oe_any |= o;
        end
    endtask

    task automatic get_byte(output logic [7:0] b, output logic oe_all);
        logic s, o;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xfer(1'b0, s, o);
            b[i] = s;
            oe_all &= o;
        end
    endtask

    task automatic t_reset();
        check("R1 so_oe low in reset", {31'd0, so_oe}, 32'd0);
        rst = 1'b0;
        wait_clk(4);
        check("R1 so_oe low after reset", {31'd0, so_oe}, 32'd0);
    endtask

    task automatic t_single();
        logic oe_any, oe_all;
        logic [7:0] b;
        select();
        send_hdr(8'h03, 16'h0010, oe_any);
        check("R3 hi-z during header", {31'd0, oe_any}, 32'd0);
        get_byte(b, oe_all);
        check("R2 R4 single byte", {24'd0, b}, {24'd0, model[16]});
        check("R4 so_oe driven in data", {31'd0, oe_all}, 32'd1);
        deselect();
        check("R8 so_oe low after cs", {31'd0, so_oe}, 32'd0);
    endtask

    task automatic t_burst_wrap();
        logic oe_any, oe_all;
        logic [7:0] b;
        select();
        send_hdr(8'h03, 16'h7A3D, oe_any);
        for (int k = 0; k < 5; k++) begin
            get_byte(b, oe_all);
            check(k < 3 ? "R5 burst increment" : "R6 wrap to zero",
                  {24'd0, b}, {24'd0, model[(16'h3D + k) % DEPTH]});
        end
        deselect();
    endtask

    task automatic t_bad_opcode();
        logic oe_any, oe_all;
        logic [7:0] b;
        select();
        send_hdr(8'h0B, 16'h0004, oe_any);
        get_byte(b, oe_all);
        check("R7 header hi-z", {31'd0, oe_any}, 32'd0);
        get_byte(b, oe_all);
        check("R7 stays hi-z after other opcode", {31'd0, oe_all}, 32'd0);
        deselect();
    endtask

    task automatic t_abort_hdr();
        logic s, o, oe_any, oe_all;
        logic [7:0] b;
        select();
        for (int i = 0; i < 12; i++) xfer(1'b1, s, o);
        deselect();
        select();
        send_hdr(8'h03, 16'h0020, oe_any);
        get_byte(b, oe_all);
        check("R8 fresh frame after header abort", {24'd0, b}, {24'd0, model[32]});
        deselect();
    endtask

    task automatic t_abort_data();
        logic s, o, oe_any;
        select();
        send_hdr(8'h03, 16'h0001, oe_any);
        for (int i = 0; i < 3; i++) xfer(1'b0, s, o);
        check("R4 driving mid byte", {31'd0, so_oe}, 32'd1);
        @(negedge clk);
        cs_n = 1'b1;
        wait_clk(4);
        check("R8 release within sync+2", {31'd0, so_oe}, 32'd0);
        wait_clk(4 * HALF);
    endtask

    task automatic t_backdoor();
        logic oe_any, oe_all;
        logic [7:0] b;
        load(5, 8'hA5);
        select();
        send_hdr(8'h03, 16'h0005, oe_any);
        get_byte(b, oe_all);
        check("R9 backdoor byte read", {24'd0, b}, 32'h0000_00A5);
        deselect();
    endtask

    initial begin
        wait_clk(3);
        for (int a = 0; a < DEPTH; a++) load(a, 8'((a * 29 + 91) & 8'hFF));
        t_reset();
        t_single();
        t_burst_wrap();
        t_bad_opcode();
        t_abort_hdr();
        t_abort_data();
        t_backdoor();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule